// File: doc/BRIEF.md
# Chip-Select Transfer Acknowledge Controller

This block owns the single active-low, open-drain transfer-acknowledge line of a bus unit. For every bus cycle it decides where the acknowledge comes from. Cycles that hit a chip-select using internal wait states, and accesses to the on-chip register space, are acknowledged by this block. The block pulls the line low after a counted number of clocks. Cycles to unmapped addresses, and cycles to chip-selects set up for external acknowledge, leave the line alone. Those cycles wait for outside logic to pull it low.

The bus unit sees one outcome in both cases: a one-clock completion pulse. The block never drives the line high. It either pulls it low or lets it float. While another master holds the bus grant, the block releases the line and abandons any cycle it was tracking.

Each chip-select carries a 3-bit wait code. The values 0 to 6 give the internal wait count, and the value 7 selects external acknowledge. The address decoder that produces the hit signals sits outside this block.

Top module: `dtack_ctrl`

## Requirements
- R1: After reset, `ackDriveEn` and `cycleDone` are both 0.
- R2: For a chip-select hit with wait code N in 0..6, take edge k as the first rising edge that samples `busStrobe` high. `ackDriveEn` rises and `cycleDone` pulses after edge k+N. Neither is asserted before that edge.
- R3: When `regHit` is set, the cycle is acknowledged internally with a wait count of zero, whatever `csHit` and the wait codes hold.
- R4: For a chip-select hit with wait code 7, `ackDriveEn` stays 0 for the whole cycle. `cycleDone` pulses after edge j+2, where j is the first edge that samples `ackPinIn` low.
- R5: A cycle with no `csHit` bit and no `regHit` behaves as in R4. It completes only through `ackPinIn`.
- R6: Once asserted, `ackDriveEn` stays 1 while `busStrobe` is high. It returns to 0 after the first edge that samples `busStrobe` low.
- R7: While `busGranted` is 1, `ackDriveEn` is 0 in the same cycle. Any cycle in progress is dropped without a `cycleDone` pulse.
- R8: `cycleDone` is one clock wide and occurs at most once per strobe. A strobe that negates before its acknowledge produces no pulse.
- R9: When several `csHit` bits are set, the lowest-numbered chip-select's wait code is used.
- R10: In an internally acknowledged cycle, the level of `ackPinIn` does not affect when `cycleDone` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busStrobe | input | 1 | Address strobe, 1 while a cycle is in progress |
| csHit | input | NUM_CS | Chip-select hit flags from the address decoder |
| regHit | input | 1 | Cycle targets the on-chip register space |
| csWaitCfg | input | NUM_CS*WAIT_W | Wait code per chip-select; chip-select i occupies bits [i*WAIT_W +: WAIT_W]; all ones selects external acknowledge |
| busGranted | input | 1 | Another master owns the bus |
| ackPinIn | input | 1 | Level sensed on the acknowledge line, 0 means asserted |
| ackDriveEn | output | 1 | 1 pulls the acknowledge line low, 0 releases it |
| cycleDone | output | 1 | One-clock completion pulse to the bus unit |

## Verification
The cycle counter's terminal count can fall in the same cycle as a bus grant. The release can also fall in the same cycle as a completion that is already being driven. The bench starts an internal cycle with a long wait code and raises the grant partway through it. It then expects no completion pulse and checks for a released line on every cycle of the grant. A second case raises the grant while the line is already pulled low. The bench requires the drive enable to fall in that same cycle. A scoreboard holds the cycle number at which each completion is due. Any pulse that arrives early, late, or after an aborted cycle shows up as a mismatch against it.

// File: rtl/dtack_pkg.sv
package dtack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAITINT = 2'd1,
    ST_WAITEXT = 2'd2,
    ST_DONE    = 2'd3
  } ackState_t;

  typedef struct packed {
    logic loadCnt;
    logic incCnt;
  } ctrlStrobe_t;
endpackage

// File: rtl/dtack_datapath.sv
module dtack_datapath
  import dtack_pkg::*;
#(
  parameter int NUM_CS      = 4,
  parameter int WAIT_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CS-1:0]        csHit,
  input  logic                     regHit,
  input  logic [NUM_CS*WAIT_W-1:0] csWaitCfg,
  input  logic                     ackPinIn,
  input  ctrlStrobe_t              strobe,
  output logic                     selExt,
  output logic                     selZero,
  output logic                     cntHit,
  output logic                     ackSeen
);
  localparam logic [WAIT_W-1:0] EXT_CODE = {WAIT_W{1'b1}};
  localparam logic [WAIT_W-1:0] CNT_ONE  = WAIT_W'(1);

  logic [WAIT_W-1:0] selWait;
  logic              anyHit;
  logic [WAIT_W-1:0] waitReg;
  logic [WAIT_W-1:0] cnt;

  // Lowest-numbered hit wins (R9); register space forces zero wait (R3)
  always_comb begin
    selWait = '0;
    anyHit  = 1'b0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (csHit[i]) begin
        selWait = csWaitCfg[i*WAIT_W +: WAIT_W];
        anyHit  = 1'b1;
      end
    end
    if (regHit) begin
      selWait = '0;
      anyHit  = 1'b1;
    end
  end

  assign selExt  = !regHit && (!anyHit || selWait == EXT_CODE);
  assign selZero = (selWait == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitReg <= '0;
      cnt     <= '0;
    end else if (strobe.loadCnt) begin
      waitReg <= selWait;
      cnt     <= CNT_ONE;
    end else if (strobe.incCnt) begin
      cnt <= cnt + CNT_ONE;
    end
  end

  assign cntHit = (cnt == waitReg);

  // Synchronizer chain for the external acknowledge (active-high after inversion)
  logic [SYNC_STAGES-1:0] syncChain;
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 1'b0;
        else if (g == 0) syncChain[g] <= ~ackPinIn;
        else syncChain[g] <= syncChain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate
  assign ackSeen = syncChain[SYNC_STAGES-1];

  assert_load_starts_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCnt |=> (cnt == CNT_ONE));
endmodule

// File: rtl/dtack_control.sv
module dtack_control
  import dtack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busStrobe,
  input  logic        busGranted,
  input  logic        selExt,
  input  logic        selZero,
  input  logic        cntHit,
  input  logic        ackSeen,
  output ctrlStrobe_t strobe,
  output logic        driveReg,
  output logic        cycleDone
);
  ackState_t state;

  assign strobe.loadCnt = (state == ST_IDLE) && busStrobe && !busGranted;
  assign strobe.incCnt  = (state == ST_WAITINT) && !cntHit && !busGranted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      driveReg  <= 1'b0;
      cycleDone <= 1'b0;
    end else begin
      cycleDone <= 1'b0;
      if (busGranted) begin
        state    <= ST_IDLE;
        driveReg <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (busStrobe) begin
              if (selExt) begin
                state <= ST_WAITEXT;
              end else if (selZero) begin
                state     <= ST_DONE;
                driveReg  <= 1'b1;
                cycleDone <= 1'b1;
              end else begin
                state <= ST_WAITINT;
              end
            end
          end
          ST_WAITINT: begin
            if (!busStrobe) begin
              state <= ST_IDLE;
            end else if (cntHit) begin
              state     <= ST_DONE;
              driveReg  <= 1'b1;
              cycleDone <= 1'b1;
            end
          end
          ST_WAITEXT: begin
            if (!busStrobe) begin
              state <= ST_IDLE;
            end else if (ackSeen) begin
              state     <= ST_DONE;
              cycleDone <= 1'b1;
            end
          end
          ST_DONE: begin
            if (!busStrobe) begin
              state    <= ST_IDLE;
              driveReg <= 1'b0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_ext_never_drives_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITEXT) |-> !driveReg);
  assert_drive_with_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveReg) |-> cycleDone);
  assert_release_after_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busStrobe |=> !driveReg);
  assert_done_one_clock_R8: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);
  assert_grant_drops_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    busGranted |=> (!cycleDone && !driveReg));
endmodule

// File: rtl/dtack_ctrl.sv
module dtack_ctrl
  import dtack_pkg::*;
#(
  parameter int NUM_CS      = 4,
  parameter int WAIT_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busStrobe,
  input  logic [NUM_CS-1:0]        csHit,
  input  logic                     regHit,
  input  logic [NUM_CS*WAIT_W-1:0] csWaitCfg,
  input  logic                     busGranted,
  input  logic                     ackPinIn,
  output logic                     ackDriveEn,
  output logic                     cycleDone
);
  ctrlStrobe_t strobe;
  logic selExt, selZero, cntHit, ackSeen, driveReg;

  dtack_datapath #(
    .NUM_CS(NUM_CS), .WAIT_W(WAIT_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .csHit(csHit), .regHit(regHit),
    .csWaitCfg(csWaitCfg), .ackPinIn(ackPinIn), .strobe(strobe),
    .selExt(selExt), .selZero(selZero), .cntHit(cntHit), .ackSeen(ackSeen)
  );

  dtack_control u_control (
    .clk(clk), .rstN(rstN), .busStrobe(busStrobe), .busGranted(busGranted),
    .selExt(selExt), .selZero(selZero), .cntHit(cntHit), .ackSeen(ackSeen),
    .strobe(strobe), .driveReg(driveReg), .cycleDone(cycleDone)
  );

  // Release the line immediately when another master owns the bus (R7)
  assign ackDriveEn = driveReg & ~busGranted;
endmodule

// File: tb/dtack_ctrl_tb.sv
module dtack_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CS = 4;
  localparam int WAIT_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busStrobe = 1'b0;
  logic [NUM_CS-1:0] csHit = '0;
  logic regHit = 1'b0;
  logic [NUM_CS*WAIT_W-1:0] csWaitCfg = '0;
  logic busGranted = 1'b0;
  logic extPull = 1'b0;
  logic ackPinIn;
  logic ackDriveEn, cycleDone;

  int cyc = 0;
  int nCompared = 0;
  int nMismatched = 0;
  int expQ[$];
  bit finished = 1'b0;

  // Open-drain line: low if the block or external logic pulls it
  assign ackPinIn = ~(ackDriveEn | extPull);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dtack_ctrl #(.NUM_CS(NUM_CS), .WAIT_W(WAIT_W)) u_dut (
    .clk(clk), .rstN(rstN), .busStrobe(busStrobe), .csHit(csHit),
    .regHit(regHit), .csWaitCfg(csWaitCfg), .busGranted(busGranted),
    .ackPinIn(ackPinIn), .ackDriveEn(ackDriveEn), .cycleDone(cycleDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nCompared++;
    if (!ok) begin
      nMismatched++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: pops the due cycle for each completion pulse
  always @(negedge clk) begin
    if (rstN && cycleDone && !finished) begin
      if (expQ.size() == 0) check(1'b0, "R8 unexpected done", cyc, -1);
      else begin
        int e;
        e = expQ.pop_front();
        check(cyc == e, "R2/R4 done cycle", cyc, e);
      end
    end
  end

  task automatic stepClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setCfg(input int cs, input int code);
    csWaitCfg[cs*WAIT_W +: WAIT_W] = WAIT_W'(code);
  endtask

  task automatic endCycle();
    busStrobe = 1'b0; extPull = 1'b0;
    stepClk(1);
    check(ackDriveEn == 1'b0, "R6 release", ackDriveEn, 0);
    csHit = '0; regHit = 1'b0;
    stepClk(4);
  endtask

  // Internal cycle with expected wait n
  task automatic intCycle(input logic [NUM_CS-1:0] hits, input bit reg_, input int n,
                          input string req);
    int c0;
    csHit = hits; regHit = reg_; busStrobe = 1'b1;
    c0 = cyc;
    expQ.push_back(c0 + 1 + n);
    stepClk(n);
    check(ackDriveEn == 1'b0, {req, " early drive"}, ackDriveEn, 0);
    stepClk(1);
    check(ackDriveEn == 1'b1, {req, " drive"}, ackDriveEn, 1);
    stepClk(2);
    check(ackDriveEn == 1'b1, "R6 held", ackDriveEn, 1);
    endCycle();
  endtask

  // External cycle: pin pulled after 3 clocks
  task automatic extCycle(input logic [NUM_CS-1:0] hits, input string req);
    csHit = hits; busStrobe = 1'b1;
    stepClk(3);
    check(ackDriveEn == 1'b0, {req, " no drive"}, ackDriveEn, 0);
    extPull = 1'b1;
    expQ.push_back(cyc + 3);
    stepClk(5);
    check(ackDriveEn == 1'b0, {req, " no drive after ack"}, ackDriveEn, 0);
    endCycle();
  endtask

  initial begin
    setCfg(0, 2); setCfg(1, 0); setCfg(2, 6); setCfg(3, 7);
    stepClk(3);
    check(ackDriveEn == 1'b0, "R1 drive", ackDriveEn, 0);
    check(cycleDone == 1'b0, "R1 done", cycleDone, 0);
    rstN = 1'b1;
    stepClk(2);

    intCycle(4'b0001, 1'b0, 2, "R2 cs0");
    intCycle(4'b0010, 1'b0, 0, "R2 cs1");
    intCycle(4'b0100, 1'b0, 6, "R2 cs2");
    intCycle(4'b0100, 1'b1, 0, "R3 reg");
    intCycle(4'b0110, 1'b0, 0, "R9 cs1 over cs2");
    intCycle(4'b1101, 1'b0, 2, "R9 cs0 over cs3");
    extCycle(4'b1000, "R4");
    extCycle(4'b0000, "R5");

    // R10: pin held low by outside logic during an internal cycle
    setCfg(2, 5);
    extPull = 1'b1;
    intCycle(4'b0100, 1'b0, 5, "R10 pin ignored");

    // R8: strobe negated before the count expires, no pulse
    setCfg(2, 6);
    csHit = 4'b0100; busStrobe = 1'b1;
    stepClk(3);
    busStrobe = 1'b0;
    stepClk(10);
    csHit = '0;
    check(expQ.size() == 0, "R8 abort", expQ.size(), 0);

    // R7: grant mid-count drops the cycle
    csHit = 4'b0100; busStrobe = 1'b1;
    stepClk(2);
    busGranted = 1'b1;
    for (int i = 0; i < 8; i++) begin
      stepClk(1);
      check(ackDriveEn == 1'b0, "R7 released mid-count", ackDriveEn, 0);
    end
    busStrobe = 1'b0;
    stepClk(1);
    busGranted = 1'b0;
    stepClk(4);

    // R7: grant while the line is pulled low
    csHit = 4'b0010; busStrobe = 1'b1;
    expQ.push_back(cyc + 1);
    stepClk(2);
    check(ackDriveEn == 1'b1, "R7 driving before grant", ackDriveEn, 1);
    busGranted = 1'b1;
    #1;
    check(ackDriveEn == 1'b0, "R7 same-cycle release", ackDriveEn, 0);
    busStrobe = 1'b0;
    stepClk(2);
    busGranted = 1'b0;
    csHit = '0;
    stepClk(4);

    // R4 again after grant traffic
    extCycle(4'b1000, "R4 repeat");

    finished = 1'b1;
    check(expQ.size() == 0, "R8 missing done", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nCompared++;
    nMismatched++;
    $display("FAIL watchdog: actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end
endmodule